// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Qualifier

This block compares a reference edge stream with a divided feedback edge stream for a phase-locked loop and turns their relative timing into two charge-pump enables. A reference rising edge with no correction pending requests an upward correction. A feedback rising edge with no correction pending requests a downward correction. Whichever edge arrives second ends the pending correction. When neither enable is set, the error output is treated as undriven. Both inputs are asynchronous to the fast system clock. Each input passes through a two-flop synchroniser before its rising edges are detected.

A phase-quality output, `phase_ok`, is low whenever either correction is active and high otherwise, so it rests high while the loop is in lock. A qualifier measures how many system clocks `phase_ok` spends low in each reference period. It raises `locked` after sixteen consecutive periods below a programmable threshold. A single period that reaches the threshold drops `locked` again.

Top module: `phase_freq_detector`

## Requirements
- R1: Each input is synchronised by two flops and edge-detected. An input rising edge set up before clock edge k is reflected in the outputs after clock edge k+2.
- R2: In the idle state, a reference rising edge alone asserts `pump_up`.
- R3: In the idle state, a feedback rising edge alone asserts `pump_dn`.
- R4: While `pump_up` is set, a feedback edge returns to idle. While `pump_dn` is set, a reference edge returns to idle.
- R5: A repeated edge of the kind that started the correction keeps the current state (reference while up, feedback while down).
- R6: Reference and feedback edges detected in the same system clock cycle leave or return the detector to idle from any state.
- R7: `pump_up` and `pump_dn` are never both high. `phase_ok` is high exactly when both are low.
- R8: At each reference edge, the period just ended counts as good if the number of clocks `phase_ok` was low since the previous reference edge is below `lock_thresh`. `locked` rises when the sixteenth consecutive good period ends.
- R9: A period whose low count reaches `lock_thresh` clears `locked` and restarts the good-period count from zero.
- R10: A synchronous reset returns the detector to idle, clears both enables, drives `phase_ok` high and clears `locked` and the good-period count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference edge stream, asynchronous |
| fb_in | input | 1 | Divided feedback edge stream, asynchronous |
| lock_thresh | input | CNT_W | Largest low count, exclusive, that still counts as a good period |
| pump_up | output | 1 | Upward correction enable |
| pump_dn | output | 1 | Downward correction enable |
| phase_ok | output | 1 | High when no correction is active |
| locked | output | 1 | Lock qualifier flag |

## Verification
The embedded properties check the following on every cycle:
- The two enables are mutually exclusive and agree with `phase_ok`.
- A lone edge from idle raises the matching enable.
- Coincident edges always land in idle.
- A bad period always clears `locked`, and `locked` only rises on a reference edge.
- Reset produces its quiet state.

Some behaviours can only be shown by the bench's scenarios:
- The full walk through state and edge combinations, including repeated same-side edges.
- The exact count of sixteen good periods before lock.
- Restarting that count after a bad period.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2
    } pfd_state_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_in};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rise = s_q.chain[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic pump_up,
    output logic pump_dn,
    output logic phase_ok
);
    typedef struct packed {
        pfd_state_e st;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (ref_rise && fb_rise) begin
            c_d.st = ST_IDLE;
        end else begin
            unique case (c_q.st)
                ST_IDLE: begin
                    if (ref_rise)     c_d.st = ST_UP;
                    else if (fb_rise) c_d.st = ST_DN;
                end
                ST_UP:   if (fb_rise)  c_d.st = ST_IDLE;
                ST_DN:   if (ref_rise) c_d.st = ST_IDLE;
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q.st <= ST_IDLE;
        else     c_q    <= c_d;
    end

    assign pump_up  = (c_q.st == ST_UP);
    assign pump_dn  = (c_q.st == ST_DN);
    assign phase_ok = (c_q.st == ST_IDLE);

    // R7
    excl_pump_chk: assert property (@(posedge clk) disable iff (rst)
        !(pump_up && pump_dn) && (phase_ok == !(pump_up || pump_dn)));

    // R2
    ref_starts_up_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_ok && ref_rise && !fb_rise) |=> pump_up);

    // R3
    fb_starts_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_ok && fb_rise && !ref_rise) |=> pump_dn);

    // R6
    both_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && fb_rise) |=> phase_ok);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (phase_ok && !pump_up && !pump_dn));
endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
    parameter int CNT_W        = 16,
    parameter int LOCK_PERIODS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_rise,
    input  logic             phase_ok,
    input  logic [CNT_W-1:0] lock_thresh,
    output logic             locked
);
    localparam int GOOD_W = $clog2(LOCK_PERIODS + 1);
    localparam logic [CNT_W-1:0]  LOW_MAX  = '1;
    localparam logic [GOOD_W-1:0] GOOD_TOP = GOOD_W'(LOCK_PERIODS);

    typedef struct packed {
        logic [CNT_W-1:0]  low_cnt;
        logic [GOOD_W-1:0] good_cnt;
        logic              locked;
    } lq_t;

    lq_t l_d, l_q;
    logic period_bad;

    assign period_bad = (l_q.low_cnt >= lock_thresh);

    always_comb begin
        l_d = l_q;
        if (ref_rise) begin
            l_d.low_cnt = '0;
            if (period_bad) begin
                l_d.good_cnt = '0;
                l_d.locked   = 1'b0;
            end else begin
                if (l_q.good_cnt != GOOD_TOP) l_d.good_cnt = l_q.good_cnt + 1'b1;
                l_d.locked = (l_d.good_cnt == GOOD_TOP);
            end
        end else if (!phase_ok && l_q.low_cnt != LOW_MAX) begin
            l_d.low_cnt = l_q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) l_q <= '0;
        else     l_q <= l_d;
    end

    assign locked = l_q.locked;

    // R9
    bad_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && period_bad) |=> !locked);

    // R8
    lock_on_ref_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(ref_rise));
endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector #(
    parameter int SYNC_STAGES  = 2,
    parameter int CNT_W        = 16,
    parameter int LOCK_PERIODS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [CNT_W-1:0] lock_thresh,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             phase_ok,
    output logic             locked
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise;

    assign raw_in = {fb_in, ref_in};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw_in[g]),
            .rise     (rise[g])
        );
    end

    pfd_core i_core (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (rise[0]),
        .fb_rise  (rise[1]),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .phase_ok (phase_ok)
    );

    pfd_lock_qual #(.CNT_W(CNT_W), .LOCK_PERIODS(LOCK_PERIODS)) i_lock (
        .clk         (clk),
        .rst         (rst),
        .ref_rise    (rise[0]),
        .phase_ok    (phase_ok),
        .lock_thresh (lock_thresh),
        .locked      (locked)
    );
endmodule

// File: tb/test_phase_freq_detector.sv
module test_phase_freq_detector;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic [CNT_W-1:0] lock_thresh = 16'd8;
    logic pump_up, pump_dn, phase_ok, locked;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    phase_freq_detector #(.CNT_W(CNT_W)) i_phase_freq_detector (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .lock_thresh(lock_thresh), .pump_up(pump_up), .pump_dn(pump_dn),
        .phase_ok(phase_ok), .locked(locked)
    );

    // {ref edge, fb edge, expected up, expected dn}
    localparam logic [3:0] TBL [11] = '{
        4'b1010, // R2 idle + ref -> up
        4'b1010, // R5 up + ref -> stays up
        4'b0100, // R4 up + fb -> idle
        4'b0101, // R3 idle + fb -> dn
        4'b0101, // R5 dn + fb -> stays dn
        4'b1000, // R4 dn + ref -> idle
        4'b1100, // R6 idle + both -> idle
        4'b1010, // R2 idle + ref -> up
        4'b1100, // R6 up + both -> idle
        4'b0101, // R3 idle + fb -> dn
        4'b1100  // R6 dn + both -> idle
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit r, input bit f, input int rest);
        ref_in = r;
        fb_in  = f;
        repeat (3) @(negedge clk);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (rest) @(negedge clk);
    endtask

    task automatic ref_then_fb();
        ref_in = 1'b1;
        @(negedge clk);
        fb_in = 1'b1;
        repeat (3) @(negedge clk);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!pump_up && !pump_dn && phase_ok && !locked, "R10 reset",
              {pump_up, pump_dn, phase_ok, locked}, 4'b0010);

        // R1 timing: visible only after the third clock edge
        ref_in = 1'b1;
        repeat (2) @(negedge clk);
        check(!pump_up, "R1 not yet", pump_up, 0);
        @(negedge clk);
        check(pump_up, "R1 after sync", pump_up, 1);
        ref_in = 1'b0;
        pulse(0, 1, 3);
        check(phase_ok, "R1 back idle", phase_ok, 1);

        for (int i = 0; i < 11; i++) begin
            pulse(TBL[i][3], TBL[i][2], 3);
            check(pump_up == TBL[i][1], "R2/R3/R4/R5/R6 up", pump_up, TBL[i][1]);
            check(pump_dn == TBL[i][0], "R2/R3/R4/R5/R6 dn", pump_dn, TBL[i][0]);
            check(phase_ok == !(TBL[i][1] | TBL[i][0]), "R7 phase_ok", phase_ok,
                  !(TBL[i][1] | TBL[i][0]));
        end

        // R10 reset out of a correction
        pulse(0, 1, 3);
        check(pump_dn, "R10 pre dn", pump_dn, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!pump_dn && phase_ok && !locked, "R10 reset from dn",
              {pump_dn, phase_ok, locked}, 3'b010);

        // R8 lock after sixteen good periods
        for (int i = 0; i < 15; i++) pulse(1, 1, 5);
        check(!locked, "R8 after 15", locked, 0);
        pulse(1, 1, 5);
        check(locked, "R8 after 16", locked, 1);

        // R9 bad period
        pulse(1, 0, 20);
        check(locked, "R8 still locked", locked, 1);
        pulse(0, 1, 3);
        ref_then_fb();
        check(!locked, "R9 unlocked", locked, 0);
        for (int i = 0; i < 15; i++) pulse(1, 1, 5);
        check(!locked, "R9 count restarted", locked, 0);
        pulse(1, 1, 5);
        check(locked, "R9 relock", locked, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule